// File: doc/BRIEF.md
# Software Trap and Return Controller

This block sits beside the decode stage of a 32-bit core. It carries out the state changes for a software trap and for a return from exception. On a trap it does four things. It saves the address of the following instruction and the current status word into a pair of exception shadow registers. It writes a cause code taken from the 5-bit trap number. It produces an updated status word in which the exception-pending and interrupt-disable bits are set. It redirects the program counter to one of two fixed entry addresses.

On a return it produces a restored PC and status word. These come either from the exception shadow pair or from a fatal-error shadow pair that is supplied from outside. The choice depends on two bits of the current status word. Every update lands on one clock edge. A single-cycle valid pulse qualifies the redirect PC and the new status word that go back to the core.

The status word bit positions are fixed: interrupt-disable is bit 5, exception-pending is bit 6 and fatal-pending is bit 7.

Top module: `swtrap_ctrl`

## Requirements
- R1: One cycle after `trap_req` is sampled high, `exc_pc` equals the sampled `cur_pc` plus 4, modulo 2^32.
- R2: One cycle after a trap, `exc_psw` equals the `cur_psw` that was sampled with it.
- R3: One cycle after a trap, `cause` bits 15:0 equal 0x0040 plus the trap number, and bits 31:16 are zero.
- R4: One cycle after a trap, `psw_out` equals the sampled `cur_psw` with bit 5 and bit 6 forced to 1 and every other bit unchanged.
- R5: A trap number from 0x00 to 0x0F gives `redir_pc` = 0x00000040. A trap number from 0x10 to 0x1F gives `redir_pc` = 0x00000050.
- R6: On a return with `cur_psw` bit 6 = 1, `redir_pc` and `psw_out` take the values of `exc_pc` and `exc_psw`.
- R7: On a return with bit 6 = 0 and bit 7 = 1, `redir_pc` and `psw_out` take the values of `fat_pc` and `fat_psw`.
- R8: On a return with bit 6 = 0 and bit 7 = 0, `redir_pc` and `psw_out` take the values of `exc_pc` and `exc_psw`.
- R9: `redir_vld` is high for exactly the one cycle after a sampled trap or return strobe and low otherwise. While it is low, `redir_pc` and `psw_out` keep their last values.
- R10: A return, or a cycle with no strobe, leaves `exc_pc`, `exc_psw` and `cause` unchanged.
- R11: When `trap_req` and `ret_req` are both high, the trap is performed and the return is ignored.
- R12: While reset is asserted, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Decoded trap instruction strobe |
| trap_code | input | 5 | Trap number from the instruction immediate |
| ret_req | input | 1 | Decoded return-from-exception strobe |
| cur_pc | input | 32 | PC of the instruction being executed |
| cur_psw | input | 32 | Current status word |
| fat_pc | input | 32 | Fatal-error saved PC |
| fat_psw | input | 32 | Fatal-error saved status word |
| exc_pc | output | 32 | Exception saved PC register |
| exc_psw | output | 32 | Exception saved status register |
| cause | output | 32 | Exception cause register |
| redir_pc | output | 32 | PC redirect target |
| psw_out | output | 32 | Status word for the core to load |
| redir_vld | output | 1 | One-cycle qualifier for redir_pc and psw_out |

## Verification
The case that is hardest to reach is a return that must ignore freshly saved exception state. After a trap, the core's status word would normally carry exception-pending, and that selects the exception pair. Reaching the fatal pair needs exception-pending clear and fatal-pending set.

Because the status word is a port, the bench follows every trap with returns under all four combinations of the two selector bits. The other status bits are varied as well. Each trap number 0 to 31 is swept. Trap and return strobes are also raised together to confirm the priority.

// File: rtl/swtrap_pkg.sv
package swtrap_pkg;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned ID_BIT  = 5;
    localparam int unsigned EP_BIT  = 6;
    localparam int unsigned NP_BIT  = 7;

    localparam logic [XLEN-1:0] ENTRY_SET =
        (XLEN'(1) << ID_BIT) | (XLEN'(1) << EP_BIT);

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] epsw;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] redir_pc;
        logic [XLEN-1:0] psw_out;
        logic            vld;
    } trap_state_t;
endpackage

// File: rtl/swtrap_vec.sv
module swtrap_vec
    import swtrap_pkg::*;
#(
    parameter int unsigned    VEC_W      = 5,
    parameter int unsigned    CAUSE_W    = 16,
    parameter logic [15:0]    CAUSE_BASE = 16'h0040,
    parameter logic [XLEN-1:0] LO_ADDR   = 32'h0000_0040,
    parameter logic [XLEN-1:0] HI_ADDR   = 32'h0000_0050
) (
    input  logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  cause_val
);
    localparam int unsigned PAD_W = XLEN - CAUSE_W;

    logic [CAUSE_W-1:0] code_lo;

    // The upper half of the trap number range selects the second entry.
    assign target  = vec[VEC_W-1] ? HI_ADDR : LO_ADDR;
    assign code_lo = CAUSE_W'(CAUSE_BASE) + CAUSE_W'(vec);

    generate
        if (PAD_W > 0) begin : g_pad
            assign cause_val = {{PAD_W{1'b0}}, code_lo};
        end else begin : g_nopad
            assign cause_val = code_lo[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/swtrap_rsel.sv
module swtrap_rsel
    import swtrap_pkg::*;
(
    input  logic            ep,
    input  logic            np,
    input  logic [XLEN-1:0] exc_pc,
    input  logic [XLEN-1:0] exc_psw,
    input  logic [XLEN-1:0] fat_pc,
    input  logic [XLEN-1:0] fat_psw,
    output logic [XLEN-1:0] rest_pc,
    output logic [XLEN-1:0] rest_psw
);
    logic use_fatal;

    // Exception-pending outranks fatal-pending; with neither set, the exception pair is used.
    assign use_fatal = !ep && np;
    assign rest_pc   = use_fatal ? fat_pc  : exc_pc;
    assign rest_psw  = use_fatal ? fat_psw : exc_psw;
endmodule

// File: rtl/swtrap_ctrl.sv
module swtrap_ctrl
    import swtrap_pkg::*;
#(
    parameter int unsigned VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_code,
    input  logic             ret_req,
    input  logic [31:0]      cur_pc,
    input  logic [31:0]      cur_psw,
    input  logic [31:0]      fat_pc,
    input  logic [31:0]      fat_psw,
    output logic [31:0]      exc_pc,
    output logic [31:0]      exc_psw,
    output logic [31:0]      cause,
    output logic [31:0]      redir_pc,
    output logic [31:0]      psw_out,
    output logic             redir_vld
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    trap_state_t st_d, st_q;
    logic [XLEN-1:0] vec_target, vec_cause;
    logic [XLEN-1:0] rest_pc, rest_psw;

    swtrap_vec #(.VEC_W(VEC_W)) u_vec (
        .vec       (trap_code),
        .target    (vec_target),
        .cause_val (vec_cause)
    );

    swtrap_rsel u_rsel (
        .ep       (cur_psw[EP_BIT]),
        .np       (cur_psw[NP_BIT]),
        .exc_pc   (st_q.epc),
        .exc_psw  (st_q.epsw),
        .fat_pc   (fat_pc),
        .fat_psw  (fat_psw),
        .rest_pc  (rest_pc),
        .rest_psw (rest_psw)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (trap_req) begin
            st_d.epc      = cur_pc + PC_STEP;
            st_d.epsw     = cur_psw;
            st_d.cause    = vec_cause;
            st_d.redir_pc = vec_target;
            st_d.psw_out  = cur_psw | ENTRY_SET;
            st_d.vld      = 1'b1;
        end else if (ret_req) begin
            st_d.redir_pc = rest_pc;
            st_d.psw_out  = rest_psw;
            st_d.vld      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_pc    = st_q.epc;
    assign exc_psw   = st_q.epsw;
    assign cause     = st_q.cause;
    assign redir_pc  = st_q.redir_pc;
    assign psw_out   = st_q.psw_out;
    assign redir_vld = st_q.vld;
endmodule

// File: rtl/swtrap_chk.sv
module swtrap_chk
    import swtrap_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        trap_req,
    input logic [4:0]  trap_code,
    input logic        ret_req,
    input logic [31:0] cur_pc,
    input logic [31:0] cur_psw,
    input logic [31:0] fat_pc,
    input logic [31:0] fat_psw,
    input logic [31:0] exc_pc,
    input logic [31:0] exc_psw,
    input logic [31:0] cause,
    input logic [31:0] redir_pc,
    input logic [31:0] psw_out,
    input logic        redir_vld
);
    p_trap_epc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> exc_pc == $past(cur_pc) + 32'd4);

    p_trap_epsw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> exc_psw == $past(cur_psw));

    p_trap_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> cause == {16'h0000, 16'h0040 + {11'd0, $past(trap_code)}});

    p_trap_psw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> psw_out == ($past(cur_psw) | 32'h0000_0060));

    p_trap_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> redir_pc == ($past(trap_code[4]) ? 32'h50 : 32'h40));

    p_ret_ep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && cur_psw[6]) |=>
            (redir_pc == $past(exc_pc) && psw_out == $past(exc_psw)));

    p_ret_np_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && !cur_psw[6] && cur_psw[7]) |=>
            (redir_pc == $past(fat_pc) && psw_out == $past(fat_psw)));

    p_ret_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && !cur_psw[6] && !cur_psw[7]) |=>
            (redir_pc == $past(exc_pc) && psw_out == $past(exc_psw)));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req || ret_req) |=> redir_vld);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req || ret_req) |=> (!redir_vld && $stable(redir_pc) && $stable(psw_out)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> ($stable(exc_pc) && $stable(exc_psw) && $stable(cause)));

    p_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && ret_req) |=> (psw_out[6] && psw_out[5] && cause[6]));
endmodule

bind swtrap_ctrl swtrap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .trap_code (trap_code),
    .ret_req   (ret_req),
    .cur_pc    (cur_pc),
    .cur_psw   (cur_psw),
    .fat_pc    (fat_pc),
    .fat_psw   (fat_psw),
    .exc_pc    (exc_pc),
    .exc_psw   (exc_psw),
    .cause     (cause),
    .redir_pc  (redir_pc),
    .psw_out   (psw_out),
    .redir_vld (redir_vld)
);

// File: tb/swtrap_ctrl_test.sv
`timescale 1ns/1ps
module swtrap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [4:0]  trap_code = '0;
    logic        ret_req = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psw = '0;
    logic [31:0] fat_pc = 32'hF000_1230;
    logic [31:0] fat_psw = 32'h0000_0A81;
    logic [31:0] exc_pc, exc_psw, cause, redir_pc, psw_out;
    logic        redir_vld;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [31:0] m_epc = '0, m_epsw = '0, m_cause = '0, m_rpc = '0, m_psw = '0;

    always #2.5 clk = ~clk;

    swtrap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_code(trap_code),
        .ret_req(ret_req), .cur_pc(cur_pc), .cur_psw(cur_psw),
        .fat_pc(fat_pc), .fat_psw(fat_psw), .exc_pc(exc_pc), .exc_psw(exc_psw),
        .cause(cause), .redir_pc(redir_pc), .psw_out(psw_out), .redir_vld(redir_vld)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_trap(input logic [4:0] v, input logic [31:0] pc, input logic [31:0] psw,
                           input bit also_ret);
        @(negedge clk);
        trap_req = 1'b1; ret_req = also_ret; trap_code = v; cur_pc = pc; cur_psw = psw;
        @(negedge clk);
        trap_req = 1'b0; ret_req = 1'b0;
        m_epc = pc + 32'd4; m_epsw = psw; m_cause = 32'h40 + {27'd0, v};
        m_rpc = (v < 5'd16) ? 32'h40 : 32'h50;
        m_psw = psw | 32'h60;
        chk(also_ret ? "R11 epc" : "R1 epc", exc_pc, m_epc);
        chk("R2 epsw", exc_psw, m_epsw);
        chk("R3 cause", cause, m_cause);
        chk("R4 psw_out", psw_out, m_psw);
        chk(also_ret ? "R11 vector" : "R5 vector", redir_pc, m_rpc);
        chk("R9 vld high", {31'd0, redir_vld}, 32'd1);
        @(negedge clk);
        chk("R9 vld low", {31'd0, redir_vld}, 32'd0);
        chk("R9 pc held", redir_pc, m_rpc);
    endtask

    task automatic do_ret(input logic [31:0] psw);
        string tag;
        @(negedge clk);
        ret_req = 1'b1; cur_psw = psw; cur_pc = ~psw;
        @(negedge clk);
        ret_req = 1'b0;
        if (psw[6]) begin
            tag = "R6"; m_rpc = m_epc; m_psw = m_epsw;
        end else if (psw[7]) begin
            tag = "R7"; m_rpc = fat_pc; m_psw = fat_psw;
        end else begin
            tag = "R8"; m_rpc = m_epc; m_psw = m_epsw;
        end
        chk({tag, " pc"}, redir_pc, m_rpc);
        chk({tag, " psw"}, psw_out, m_psw);
        chk("R9 vld ret", {31'd0, redir_vld}, 32'd1);
        chk("R10 epc kept", exc_pc, m_epc);
        chk("R10 epsw kept", exc_psw, m_epsw);
        chk("R10 cause kept", cause, m_cause);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 exc_pc", exc_pc, 32'd0);
        chk("R12 exc_psw", exc_psw, 32'd0);
        chk("R12 cause", cause, 32'd0);
        chk("R12 redir_pc", redir_pc, 32'd0);
        chk("R12 psw_out", psw_out, 32'd0);
        chk("R12 vld", {31'd0, redir_vld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle", {31'd0, redir_vld}, 32'd0);

        for (int v = 0; v < 32; v++) begin
            logic [31:0] pc, psw;
            pc  = 32'h1000_0000 + v * 32'h0013_5794;
            psw = v * 32'h9E37_79B9;
            if (v == 31) pc = 32'hFFFF_FFFC;
            do_trap(v[4:0], pc, psw, 1'b0);
            for (int s = 0; s < 4; s++) begin
                logic [31:0] rp;
                rp = (psw ^ (s * 32'h0101_0013)) & ~32'h0000_00C0;
                rp[6] = s[0];
                rp[7] = s[1];
                do_ret(rp);
            end
            fat_pc  = fat_pc + 32'h0000_0104;
            fat_psw = fat_psw ^ (v * 32'h0000_0111);
        end

        do_trap(5'd15, 32'h0000_2000, 32'h0000_0080, 1'b1);
        do_trap(5'd16, 32'h0000_3000, 32'h0000_0040, 1'b1);
        do_ret(32'h0000_0040);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule